// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Open/Closed Tracking

This block sits behind the command pins of a DDR3-class memory interface and turns each sampled pin set into a single decoded command. On every rising clock edge it registers chip select, the three strobe lines, the clock-enable level, the bank address and the two address modifiers. One registered clock-enable level is kept so the decode can compare the level in the previous cycle with the current one. From those registered values it drives a one-hot command vector, an auto-precharge flag, a burst-chop flag, the target bank and an illegal-command pulse.

Two small state machines sit beside the decoder. Eight per-bank machines record whether each bank holds an open row. A power machine records whether the device is awake, in power-down or in self-refresh, so that a wake-up can be reported as the correct kind of exit. The block only classifies and tracks commands. It passes all commands through and enforces no timing. Legal commands and illegal ones are reported on the same outputs and update state the same way; the illegal pulse is the only difference.

Bank machine states: `BANK_IDLE` and `BANK_ACTIVE`. The transition to active happens on an activate to that bank. The transition to idle happens on a single precharge to that bank, an all-bank precharge, or a read or write with auto-precharge to that bank. Power machine states: `PWR_AWAKE`, `PWR_DOWN` and `PWR_SELF`. The machine moves from awake to down on power-down entry and from awake to self on self-refresh entry. It returns from down or self to awake on either exit.

Top module: `sdram_cmd_decode`

## Requirements
- R1: While `rst_n` is low, `cmd_onehot` shows only the deselect bit (bit 14), `bank_open` is all zero, and `illegal_cmd`, `auto_pre` and `burst_chop` are low. The registered clock-enable level and the previous level both reset to high.
- R2: Pins sampled at a rising edge are decoded on the outputs from that edge until the next one. With clock enable high in both cycles and `cs_n` high, the decode is deselect (bit 14), whatever the other pins carry.
- R3: With clock enable high in both cycles and `cs_n` low, the decode of {`ras_n`,`cas_n`,`we_n`} is as follows, with the one-hot bit in brackets: 011 activate [0], 101 read [1], 100 write [2], 010 precharge, 001 refresh [5], 000 mode-register set [6], 110 calibration, 111 NOP [13].
- R4: A precharge with `a10` low decodes as single-bank precharge [3]. With `a10` high it decodes as all-bank precharge [4] and closes every bank in the cycle after the decode.
- R5: For reads and writes, `auto_pre` equals `a10`, and `burst_chop` is high when `otf_en` is high and `a12` is low. Both flags are low for every other decode.
- R6: A calibration command with `a10` high is long calibration [7]. With `a10` low it is short calibration [8].
- R7: When clock enable falls (previous high, current low), NOP or deselect decodes as power-down entry [9] and refresh decodes as self-refresh entry [11]. Any other command gives `illegal_cmd` with no command bit set.
- R8: When clock enable rises, NOP or deselect decodes as self-refresh exit [12] if the power machine is in `PWR_SELF`, and as power-down exit [10] otherwise. Any other command gives `illegal_cmd` with no command bit set. With clock enable low in both cycles, no command bit is set.
- R9: An activate marks its bank open and a single precharge marks its bank closed. The change shows on `bank_open` in the cycle after the decode. All other decodes leave `bank_open` unchanged.
- R10: A read or write with `auto_pre` high closes its target bank in the cycle after the decode.
- R11: `illegal_cmd` is high during the decode of an activate to an open bank, of a read or write to a closed bank, and of a refresh, self-refresh entry, mode-register set or calibration while any bank is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock-enable level |
| ba | input | BANK_AW | Bank address |
| a10 | input | 1 | Address bit 10 modifier (all-bank / auto-precharge / long calibration) |
| a12 | input | 1 | Address bit 12 modifier (low selects burst-chop) |
| otf_en | input | 1 | Static enable for on-the-fly burst-chop selection |
| cmd_onehot | output | 15 | Decoded command, one-hot, bit positions as in R3 to R8 |
| cmd_bank | output | BANK_AW | Registered bank address of the decoded command |
| auto_pre | output | 1 | Auto-precharge requested by the decoded read or write |
| burst_chop | output | 1 | Burst-chop 4 selected by the decoded read or write |
| illegal_cmd | output | 1 | Decoded command is illegal for the current state |
| bank_open | output | 2**BANK_AW | Per-bank open-row flags |

## Verification
The bench targets clock-enable transitions. A decoder that ignored the previous level would report a falling-edge NOP as a plain NOP, and one that did not track self-refresh would report every wake-up as a power-down exit. It also checks the one-cycle lag between a decode and the bank flags. An activate that opened its bank in the decode cycle, or an auto-precharge that never closed it, would show up as a wrong `bank_open` or a missed or spurious illegal pulse on the next command. The modifier bits are driven high and low on every command that uses them, and on commands that do not. This catches flags that leak into other decodes or an all-bank precharge that touches only one bank.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int CMD_NUM = 15;
    localparam int CI_ACT  = 0;
    localparam int CI_RD   = 1;
    localparam int CI_WR   = 2;
    localparam int CI_PRE  = 3;
    localparam int CI_PREA = 4;
    localparam int CI_REF  = 5;
    localparam int CI_MRS  = 6;
    localparam int CI_ZQL  = 7;
    localparam int CI_ZQS  = 8;
    localparam int CI_PDE  = 9;
    localparam int CI_PDX  = 10;
    localparam int CI_SRE  = 11;
    localparam int CI_SRX  = 12;
    localparam int CI_NOP  = 13;
    localparam int CI_DES  = 14;

    typedef enum logic [1:0] {
        PWR_AWAKE = 2'd0,
        PWR_DOWN  = 2'd1,
        PWR_SELF  = 2'd2
    } pwr_state_e;

    typedef enum logic {
        BANK_IDLE   = 1'b0,
        BANK_ACTIVE = 1'b1
    } bank_state_e;
endpackage

// File: rtl/sdcmd_capture.sv
module sdcmd_capture #(
    parameter int BANK_AW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic               cke,
    input  logic [BANK_AW-1:0] ba,
    input  logic               a10,
    input  logic               a12,
    output logic               cs_n_q,
    output logic [2:0]         rcw_q,
    output logic               cke_q,
    output logic               cke_prev_q,
    output logic [BANK_AW-1:0] ba_q,
    output logic               a10_q,
    output logic               a12_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q     <= 1'b1;
            rcw_q      <= 3'b111;
            cke_q      <= 1'b1;
            cke_prev_q <= 1'b1;
            ba_q       <= '0;
            a10_q      <= 1'b0;
            a12_q      <= 1'b0;
        end else begin
            cs_n_q     <= cs_n;
            rcw_q      <= {ras_n, cas_n, we_n};
            cke_prev_q <= cke_q;
            cke_q      <= cke;
            ba_q       <= ba;
            a10_q      <= a10;
            a12_q      <= a12;
        end
    end
endmodule

// File: rtl/sdcmd_classify.sv
module sdcmd_classify
    import sdcmd_pkg::*;
#(
    parameter int BANK_AW   = 3,
    parameter int NUM_BANKS = 1 << BANK_AW
) (
    input  logic                 cs_n_q,
    input  logic [2:0]           rcw_q,
    input  logic                 cke_q,
    input  logic                 cke_prev_q,
    input  logic [BANK_AW-1:0]   ba_q,
    input  logic                 a10_q,
    input  logic                 a12_q,
    input  logic                 otf_en,
    input  pwr_state_e           pwr_state,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic [CMD_NUM-1:0]   cmd_onehot,
    output logic                 auto_pre,
    output logic                 burst_chop,
    output logic                 illegal_cmd
);
    logic any_open;
    logic idle_pins;

    assign any_open  = |bank_open;
    assign idle_pins = cs_n_q || (rcw_q == 3'b111);

    always_comb begin
        cmd_onehot  = '0;
        auto_pre    = 1'b0;
        burst_chop  = 1'b0;
        illegal_cmd = 1'b0;
        unique case ({cke_prev_q, cke_q})
            2'b11: begin
                if (cs_n_q) begin
                    cmd_onehot[CI_DES] = 1'b1;
                end else begin
                    unique case (rcw_q)
                        3'b011: begin
                            cmd_onehot[CI_ACT] = 1'b1;
                            illegal_cmd        = bank_open[ba_q];
                        end
                        3'b010: begin
                            if (a10_q) cmd_onehot[CI_PREA] = 1'b1;
                            else       cmd_onehot[CI_PRE]  = 1'b1;
                        end
                        3'b101, 3'b100: begin
                            if (rcw_q[0]) cmd_onehot[CI_RD] = 1'b1;
                            else          cmd_onehot[CI_WR] = 1'b1;
                            auto_pre    = a10_q;
                            burst_chop  = otf_en && !a12_q;
                            illegal_cmd = !bank_open[ba_q];
                        end
                        3'b001: begin
                            cmd_onehot[CI_REF] = 1'b1;
                            illegal_cmd        = any_open;
                        end
                        3'b000: begin
                            cmd_onehot[CI_MRS] = 1'b1;
                            illegal_cmd        = any_open;
                        end
                        3'b110: begin
                            if (a10_q) cmd_onehot[CI_ZQL] = 1'b1;
                            else       cmd_onehot[CI_ZQS] = 1'b1;
                            illegal_cmd = any_open;
                        end
                        default: cmd_onehot[CI_NOP] = 1'b1;
                    endcase
                end
            end
            2'b10: begin
                if (idle_pins) begin
                    cmd_onehot[CI_PDE] = 1'b1;
                end else if (rcw_q == 3'b001) begin
                    cmd_onehot[CI_SRE] = 1'b1;
                    illegal_cmd        = any_open;
                end else begin
                    illegal_cmd = 1'b1;
                end
            end
            2'b01: begin
                if (!idle_pins)                  illegal_cmd        = 1'b1;
                else if (pwr_state == PWR_SELF)  cmd_onehot[CI_SRX] = 1'b1;
                else                             cmd_onehot[CI_PDX] = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdcmd_power_fsm.sv
module sdcmd_power_fsm
    import sdcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_enter,
    input  logic       sr_enter,
    input  logic       any_exit,
    output pwr_state_e pwr_state
);
    pwr_state_e pwr_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_state <= PWR_AWAKE;
        else        pwr_state <= pwr_nxt;
    end

    always_comb begin
        pwr_nxt = pwr_state;
        unique case (pwr_state)
            PWR_AWAKE: begin
                if (pd_enter)      pwr_nxt = PWR_DOWN;
                else if (sr_enter) pwr_nxt = PWR_SELF;
            end
            PWR_DOWN: if (any_exit) pwr_nxt = PWR_AWAKE;
            PWR_SELF: if (any_exit) pwr_nxt = PWR_AWAKE;
            default:  pwr_nxt = PWR_AWAKE;
        endcase
    end
endmodule

// File: rtl/sdcmd_bank_track.sv
module sdcmd_bank_track
    import sdcmd_pkg::*;
#(
    parameter int BANK_AW   = 3,
    parameter int NUM_BANKS = 1 << BANK_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_req,
    input  logic                 close_req,
    input  logic                 close_all,
    input  logic [BANK_AW-1:0]   ba_q,
    output logic [NUM_BANKS-1:0] bank_open
);
    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        bank_state_e st_q, st_nxt;
        logic        hit;

        assign hit = (ba_q == BANK_AW'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= BANK_IDLE;
            else        st_q <= st_nxt;
        end

        always_comb begin
            st_nxt = st_q;
            unique case (st_q)
                BANK_IDLE:   if (open_req && hit) st_nxt = BANK_ACTIVE;
                BANK_ACTIVE: if (close_all || (close_req && hit)) st_nxt = BANK_IDLE;
                default:     st_nxt = BANK_IDLE;
            endcase
        end

        assign bank_open[gi] = (st_q == BANK_ACTIVE);
    end
endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdcmd_pkg::*;
#(
    parameter int BANK_AW = 3,
    localparam int NUM_BANKS = 1 << BANK_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic [BANK_AW-1:0]   ba,
    input  logic                 a10,
    input  logic                 a12,
    input  logic                 otf_en,
    output logic [CMD_NUM-1:0]   cmd_onehot,
    output logic [BANK_AW-1:0]   cmd_bank,
    output logic                 auto_pre,
    output logic                 burst_chop,
    output logic                 illegal_cmd,
    output logic [NUM_BANKS-1:0] bank_open
);
    logic       cs_n_q, cke_q, cke_prev_q, a10_q, a12_q;
    logic [2:0] rcw_q;
    pwr_state_e pwr_state;

    sdcmd_capture #(.BANK_AW(BANK_AW)) u_cap (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .a12(a12),
        .cs_n_q(cs_n_q), .rcw_q(rcw_q), .cke_q(cke_q), .cke_prev_q(cke_prev_q),
        .ba_q(cmd_bank), .a10_q(a10_q), .a12_q(a12_q)
    );

    sdcmd_classify #(.BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS)) u_cls (
        .cs_n_q(cs_n_q), .rcw_q(rcw_q), .cke_q(cke_q), .cke_prev_q(cke_prev_q),
        .ba_q(cmd_bank), .a10_q(a10_q), .a12_q(a12_q), .otf_en(otf_en),
        .pwr_state(pwr_state), .bank_open(bank_open),
        .cmd_onehot(cmd_onehot), .auto_pre(auto_pre), .burst_chop(burst_chop),
        .illegal_cmd(illegal_cmd)
    );

    sdcmd_power_fsm u_pwr (
        .clk(clk), .rst_n(rst_n),
        .pd_enter(cmd_onehot[CI_PDE]), .sr_enter(cmd_onehot[CI_SRE]),
        .any_exit(cmd_onehot[CI_PDX] || cmd_onehot[CI_SRX]),
        .pwr_state(pwr_state)
    );

    sdcmd_bank_track #(.BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .open_req(cmd_onehot[CI_ACT]),
        .close_req(cmd_onehot[CI_PRE] ||
                   ((cmd_onehot[CI_RD] || cmd_onehot[CI_WR]) && auto_pre)),
        .close_all(cmd_onehot[CI_PREA]),
        .ba_q(cmd_bank), .bank_open(bank_open)
    );
endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker
    import sdcmd_pkg::*;
#(
    parameter int BANK_AW = 3,
    localparam int NUM_BANKS = 1 << BANK_AW
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CMD_NUM-1:0]   cmd_onehot,
    input logic [BANK_AW-1:0]   cmd_bank,
    input logic                 auto_pre,
    input logic                 burst_chop,
    input logic                 illegal_cmd,
    input logic [NUM_BANKS-1:0] bank_open
);
    logic rdwr, bank_cmd;
    assign rdwr     = cmd_onehot[CI_RD] || cmd_onehot[CI_WR];
    assign bank_cmd = rdwr || cmd_onehot[CI_ACT] || cmd_onehot[CI_PRE] || cmd_onehot[CI_PREA];

    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_onehot));

    assert_act_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[CI_ACT] |=> bank_open[$past(cmd_bank)]);

    assert_other_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_cmd |=> (bank_open == $past(bank_open)));

    assert_prea_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[CI_PREA] |=> (bank_open == '0));

    assert_autopre_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdwr && auto_pre) |=> !bank_open[$past(cmd_bank)]);

    assert_closed_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rdwr && !bank_open[cmd_bank]) |-> illegal_cmd);

    assert_flags_only_rdwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_pre || burst_chop) |-> rdwr);
endmodule

bind sdram_cmd_decode sdcmd_checker #(.BANK_AW(BANK_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank),
    .auto_pre(auto_pre), .burst_chop(burst_chop), .illegal_cmd(illegal_cmd),
    .bank_open(bank_open)
);

// File: tb/sdram_cmd_decode_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_decode_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [2:0] ba = 3'd0;
    logic       a10 = 1'b0, a12 = 1'b0, otf_en = 1'b1;
    logic [14:0] cmd_onehot;
    logic [2:0]  cmd_bank;
    logic        auto_pre, burst_chop, illegal_cmd;
    logic [7:0]  bank_open;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit m_open [8];
    int m_pwr = 0;
    bit m_prev = 1'b1;
    int pend_idx = -1;
    int pend_bank = 0;
    bit pend_ap = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_decode dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .a12(a12), .otf_en(otf_en),
        .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank), .auto_pre(auto_pre),
        .burst_chop(burst_chop), .illegal_cmd(illegal_cmd), .bank_open(bank_open)
    );

    function automatic bit any_open_m();
        for (int i = 0; i < 8; i++) if (m_open[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit c, bit r, bit s, bit w, bit k,
                        logic [2:0] b, bit x10, bit x12);
        int  idx;
        bit  ill, ap, bc, nopish;
        logic [14:0] ecmd;
        logic [7:0]  eopen;
        cs_n = c; ras_n = r; cas_n = s; we_n = w; cke = k; ba = b; a10 = x10; a12 = x12;
        @(posedge clk);
        @(negedge clk);
        // bank and power effects of the previous decode land at this edge
        case (pend_idx)
            0: m_open[pend_bank] = 1'b1;
            1, 2: if (pend_ap) m_open[pend_bank] = 1'b0;
            3: m_open[pend_bank] = 1'b0;
            4: for (int i = 0; i < 8; i++) m_open[i] = 1'b0;
            9: if (m_pwr == 0) m_pwr = 1;
            11: if (m_pwr == 0) m_pwr = 2;
            10, 12: m_pwr = 0;
            default: ;
        endcase
        idx = -1; ill = 0; ap = 0; bc = 0;
        nopish = c || (r && s && w);
        if (!m_prev && !k) begin
            idx = -1;
        end else if (m_prev && !k) begin
            if (nopish) idx = 9;
            else if (!r && !s && w) begin idx = 11; ill = any_open_m(); end
            else ill = 1;
        end else if (!m_prev && k) begin
            if (nopish) idx = (m_pwr == 2) ? 12 : 10;
            else ill = 1;
        end else if (c) begin
            idx = 14;
        end else if (r && s && w) begin
            idx = 13;
        end else if (!r && s && w) begin
            idx = 0; ill = m_open[b];
        end else if (!r && s && !w) begin
            idx = x10 ? 4 : 3;
        end else if (r && !s) begin
            idx = w ? 1 : 2; ap = x10; bc = otf_en && !x12; ill = !m_open[b];
        end else if (!r && !s && w) begin
            idx = 5; ill = any_open_m();
        end else if (!r && !s && !w) begin
            idx = 6; ill = any_open_m();
        end else begin
            idx = x10 ? 7 : 8; ill = any_open_m();
        end
        ecmd = (idx >= 0) ? (15'd1 << idx) : 15'd0;
        for (int i = 0; i < 8; i++) eopen[i] = m_open[i];
        check(tag, {4'd0, cmd_onehot, cmd_bank, illegal_cmd, auto_pre, burst_chop, bank_open},
                   {4'd0, ecmd, b, ill, ap, bc, eopen});
        m_prev = k;
        pend_idx = idx; pend_bank = b; pend_ap = ap;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_open[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {17'd0, cmd_onehot}, {17'd0, 15'h4000});
        check("R1", {24'd0, bank_open}, 32'd0);
        check("R1", {29'd0, illegal_cmd, auto_pre, burst_chop}, 32'd0);
        rst_n = 1'b1;

        step("R2", 1, 0, 0, 0, 1, 3'd5, 1, 0);
        step("R2", 1, 1, 0, 1, 1, 3'd2, 0, 1);
        step("R3", 0, 0, 0, 0, 1, 3'd0, 0, 0);
        step("R3", 0, 0, 0, 1, 1, 3'd0, 0, 0);
        step("R3", 0, 1, 1, 1, 1, 3'd0, 0, 0);
        step("R6", 0, 1, 1, 0, 1, 3'd0, 1, 0);
        step("R6", 0, 1, 1, 0, 1, 3'd0, 0, 0);
        step("R9", 0, 0, 1, 1, 1, 3'd3, 0, 0);
        step("R11", 0, 0, 1, 1, 1, 3'd3, 0, 0);
        step("R11", 0, 1, 0, 0, 1, 3'd5, 0, 1);
        step("R11", 0, 0, 0, 1, 1, 3'd0, 0, 0);
        step("R11", 0, 0, 0, 0, 1, 3'd0, 0, 0);
        step("R11", 0, 1, 1, 0, 1, 3'd0, 1, 0);
        step("R5", 0, 1, 0, 1, 1, 3'd3, 0, 0);
        step("R5", 0, 1, 0, 1, 1, 3'd3, 0, 1);
        otf_en = 1'b0;
        step("R5", 0, 1, 0, 0, 1, 3'd3, 0, 0);
        otf_en = 1'b1;
        step("R10", 0, 1, 0, 0, 1, 3'd3, 1, 1);
        step("R10", 0, 1, 1, 1, 1, 3'd0, 0, 0);
        step("R10", 0, 1, 0, 1, 1, 3'd3, 0, 1);
        step("R9", 0, 0, 1, 1, 1, 3'd0, 0, 0);
        step("R9", 0, 0, 1, 1, 1, 3'd7, 0, 0);
        step("R4", 0, 0, 1, 0, 1, 3'd0, 0, 0);
        step("R4", 0, 1, 1, 1, 1, 3'd0, 0, 0);
        step("R4", 0, 0, 1, 0, 1, 3'd1, 1, 0);
        step("R4", 0, 1, 1, 1, 1, 3'd0, 0, 0);
        step("R7", 0, 1, 1, 1, 0, 3'd0, 0, 0);
        step("R8", 0, 1, 1, 1, 0, 3'd0, 0, 0);
        step("R8", 0, 1, 1, 1, 1, 3'd0, 0, 0);
        step("R7", 0, 0, 0, 1, 0, 3'd0, 0, 0);
        step("R8", 1, 0, 0, 0, 0, 3'd0, 0, 0);
        step("R8", 1, 0, 1, 0, 1, 3'd0, 0, 0);
        step("R7", 0, 0, 1, 1, 0, 3'd1, 0, 0);
        step("R8", 0, 1, 1, 1, 0, 3'd0, 0, 0);
        step("R8", 0, 0, 1, 1, 1, 3'd1, 0, 0);
        step("R3", 0, 1, 1, 1, 1, 3'd0, 0, 0);
        step("R9", 0, 0, 1, 1, 1, 3'd2, 0, 0);
        step("R11", 0, 0, 0, 1, 0, 3'd0, 0, 0);
        step("R8", 1, 1, 1, 1, 1, 3'd0, 0, 0);
        step("R9", 0, 0, 1, 0, 1, 3'd2, 0, 0);
        step("R9", 0, 1, 1, 1, 1, 3'd0, 0, 0);
        for (int n = 0; n < 400; n++) begin
            int  roll;
            bit  k;
            roll = $urandom_range(0, 19);
            k = (roll == 0) ? ~m_prev : m_prev;
            if (!m_prev && roll > 3) k = 1'b1;
            step("R3", 1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), k,
                 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)));
        end
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule